// File: doc/BRIEF.md
# Display RAM Address Counter With Line Wrap

This block holds the 7-bit address shared by a character-display data memory and a user-glyph (character-generator) memory. A host-side controller loads it with a start address and then steps it up or down one position per access. The step sequence follows the memory layout rather than plain binary. In one-line layout the display memory is 80 contiguous cells, 00h to 4Fh, and the count wraps at both ends. In two-line layout the display memory is two 40-cell lines at 00h–27h and 40h–67h, and the count jumps over the unused hole 28h–3Fh.

When the glyph memory is selected, the counter runs modulo 64 in its low six bits and the line layout has no effect. The block does not decide when to step. It applies the strobes it receives and presents the new address one clock later. Line length, second-line base and the widths are parameters, and elaboration checks keep them consistent.

Top module: `dram_addr_ctr`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, addr is 00h.
- R2: With load_en high, the next addr is load_val when tgt_char is 0. When tgt_char is 1 it is load_val[5:0] with bit 6 forced to 0. load_en overrides inc and dec.
- R3: One-line display stepping up (tgt_char=0, two_line=0, inc=1, dec=0) adds 1, except that 4Fh or any higher value goes to 00h.
- R4: One-line display stepping down subtracts 1, except that 00h goes to 4Fh and any value above 4Fh goes to 4Fh.
- R5: Two-line display stepping up adds 1, with three exceptions. 27h goes to 40h. Any value in the hole 28h–3Fh goes to 40h. 67h and above go to 00h.
- R6: Two-line display stepping down subtracts 1, with four exceptions. 40h goes to 27h. A value in the hole goes to 27h. 00h goes to 67h. Any value above 67h goes to 67h.
- R7: With tgt_char=1, inc adds 1 and dec subtracts 1 modulo 64 on bits 5:0, bit 6 becomes 0, and two_line has no effect.
- R8: With load_en low and inc equal to dec (both low or both high), addr keeps its value.
- R9: The first step after a display load in two-line layout never lands in the hole, and never lands above 67h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load load_val into the counter |
| load_val | input | 7 | Address to load |
| inc | input | 1 | Step up one position |
| dec | input | 1 | Step down one position |
| two_line | input | 1 | 1 = two 40-cell lines, 0 = one 80-cell line |
| tgt_char | input | 1 | 1 = glyph memory selected, 0 = display memory |
| addr | output | 7 | Current address |

## Verification
Every result is due exactly one rising edge after the cycle that carries the load or strobe, since the only register on the path is the counter itself. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares addr on the next falling edge. It then drives the following stimulus. So each comparison sees only the effect of the single preceding command. Expected values come from a bench function that steps a shadow address under the rules above. Directed cases cover every wrap and hole boundary. Seeded random commands, with many load values placed near those boundaries, fill in the rest.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_UP   = 2'd2,
      ACT_DOWN = 2'd3
   } ctr_act_e;

   function automatic ctr_act_e decode_act(input logic ld, input logic up, input logic dn);
      if (ld)            return ACT_LOAD;
      else if (up && !dn) return ACT_UP;
      else if (dn && !up) return ACT_DOWN;
      else               return ACT_HOLD;
   endfunction
endpackage

// File: rtl/dram_disp_step.sv
module dram_disp_step #(
   parameter int ADDR_W     = 7,
   parameter int LINE_LEN   = 40,
   parameter int LINE2_BASE = 64
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic              two_line,
   output logic [ADDR_W-1:0] nxt_up,
   output logic [ADDR_W-1:0] nxt_dn
);
   localparam logic [ADDR_W-1:0] ONE_LAST  = ADDR_W'(2*LINE_LEN - 1);
   localparam logic [ADDR_W-1:0] L1_LAST   = ADDR_W'(LINE_LEN - 1);
   localparam logic [ADDR_W-1:0] L2_FIRST  = ADDR_W'(LINE2_BASE);
   localparam logic [ADDR_W-1:0] L2_LAST   = ADDR_W'(LINE2_BASE + LINE_LEN - 1);
   localparam logic [ADDR_W-1:0] ZERO      = '0;
   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

   logic in_hole;
   logic [ADDR_W-1:0] one_up, one_dn, two_up, two_dn;

   assign in_hole = (cur > L1_LAST) && (cur < L2_FIRST);

   always_comb begin
      if (cur >= ONE_LAST) one_up = ZERO;
      else                 one_up = cur + ONE;
      if (cur == ZERO)          one_dn = ONE_LAST;
      else if (cur > ONE_LAST)  one_dn = ONE_LAST;
      else                      one_dn = cur - ONE;
   end

   always_comb begin
      if (cur == L1_LAST || in_hole) two_up = L2_FIRST;
      else if (cur >= L2_LAST)       two_up = ZERO;
      else                           two_up = cur + ONE;
      if (cur == ZERO)                two_dn = L2_LAST;
      else if (cur == L2_FIRST || in_hole) two_dn = L1_LAST;
      else if (cur > L2_LAST)         two_dn = L2_LAST;
      else                            two_dn = cur - ONE;
   end

   assign nxt_up = two_line ? two_up : one_up;
   assign nxt_dn = two_line ? two_dn : one_dn;
endmodule

// File: rtl/dram_char_step.sv
module dram_char_step #(
   parameter int ADDR_W = 7,
   parameter int CHAR_W = 6
) (
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] nxt_up,
   output logic [ADDR_W-1:0] nxt_dn
);
   logic [CHAR_W-1:0] low_up, low_dn;
   assign low_up = cur[CHAR_W-1:0] + CHAR_W'(1);
   assign low_dn = cur[CHAR_W-1:0] - CHAR_W'(1);

   generate
      if (CHAR_W == ADDR_W) begin : g_full
         assign nxt_up = low_up;
         assign nxt_dn = low_dn;
      end else begin : g_pad
         assign nxt_up = {{(ADDR_W-CHAR_W){1'b0}}, low_up};
         assign nxt_dn = {{(ADDR_W-CHAR_W){1'b0}}, low_dn};
      end
   endgenerate
endmodule

// File: rtl/dram_addr_ctr.sv
module dram_addr_ctr #(
   parameter int ADDR_W     = 7,
   parameter int LINE_LEN   = 40,
   parameter int LINE2_BASE = 64,
   parameter int CHAR_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   input  logic              dec,
   input  logic              two_line,
   input  logic              tgt_char,
   output logic [ADDR_W-1:0] addr
);
   import dram_addr_pkg::*;

   localparam logic [ADDR_W-1:0] ONE_LAST = ADDR_W'(2*LINE_LEN - 1);
   localparam logic [ADDR_W-1:0] L1_LAST  = ADDR_W'(LINE_LEN - 1);
   localparam logic [ADDR_W-1:0] L2_FIRST = ADDR_W'(LINE2_BASE);
   localparam logic [ADDR_W-1:0] L2_LAST  = ADDR_W'(LINE2_BASE + LINE_LEN - 1);

   generate
      if (LINE2_BASE < LINE_LEN)
         $error("second line must start after the first line ends");
      if (LINE2_BASE + LINE_LEN > (1 << ADDR_W))
         $error("second line does not fit in the address width");
      if (2*LINE_LEN > (1 << ADDR_W))
         $error("single line does not fit in the address width");
      if (CHAR_W > ADDR_W || CHAR_W < 1)
         $error("glyph width must lie within the address width");
   endgenerate

   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [ADDR_W-1:0] disp_up, disp_dn, char_up, char_dn, load_cut;
   ctr_act_e act;

   dram_disp_step #(.ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)) u_disp (
      .cur(addr_q), .two_line(two_line), .nxt_up(disp_up), .nxt_dn(disp_dn));

   dram_char_step #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_char (
      .cur(addr_q), .nxt_up(char_up), .nxt_dn(char_dn));

   generate
      if (CHAR_W == ADDR_W) begin : g_ld_full
         assign load_cut = load_val;
      end else begin : g_ld_cut
         assign load_cut = {{(ADDR_W-CHAR_W){1'b0}}, load_val[CHAR_W-1:0]};
      end
   endgenerate

   assign act = decode_act(load_en, inc, dec);

   always_comb begin
      unique case (act)
         ACT_LOAD: addr_d = tgt_char ? load_cut : load_val;
         ACT_UP:   addr_d = tgt_char ? char_up  : disp_up;
         ACT_DOWN: addr_d = tgt_char ? char_dn  : disp_dn;
         default:  addr_d = addr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_d;
   end

   assign addr = addr_q;

   logic step_cmd;
   assign step_cmd = !load_en && (inc ^ dec);

   // R8: idle or conflicting strobes leave the address alone
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && (inc == dec)) |=> $stable(addr));

   // R2: glyph load clears the upper bits
   p_char_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && tgt_char) |=> (addr >> CHAR_W) == '0);

   // R3: one-line up stays in the 80-cell window
   p_one_up_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && inc && !tgt_char && !two_line) |=> addr <= ONE_LAST);

   // R4: one-line down stays in the 80-cell window
   p_one_dn_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && dec && !tgt_char && !two_line) |=> addr <= ONE_LAST);

   // R5/R6: two-line steps never land in the hole or past line two
   p_two_no_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && !tgt_char && two_line) |=>
         (addr <= L1_LAST || (addr >= L2_FIRST && addr <= L2_LAST)));

   // R6: step down from the second-line start goes to the first-line end
   p_two_dn_seam_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && dec && !tgt_char && two_line && addr == L2_FIRST) |=> addr == L1_LAST);

   // R7: glyph stepping stays in the glyph range
   p_char_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && tgt_char) |=> (addr >> CHAR_W) == '0);
endmodule

// File: tb/dram_addr_ctr_tb.sv
`timescale 1ns/1ps
module dram_addr_ctr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0;
   logic [6:0] load_val = '0;
   logic       inc = 1'b0;
   logic       dec = 1'b0;
   logic       two_line = 1'b0;
   logic       tgt_char = 1'b0;
   logic [6:0] addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   logic [6:0] shadow = '0;

   always #10 clk = ~clk;

   dram_addr_ctr dut_i (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
      .inc(inc), .dec(dec), .two_line(two_line), .tgt_char(tgt_char), .addr(addr));

   function automatic logic [6:0] model(input logic [6:0] a, input logic ld, input logic [6:0] lv,
                                        input logic up, input logic dn, input logic tl, input logic tc);
      if (ld) return tc ? {1'b0, lv[5:0]} : lv;
      if (up == dn) return a;
      if (tc) return up ? {1'b0, a[5:0] + 6'd1} : {1'b0, a[5:0] - 6'd1};
      if (!tl) begin
         if (up) return (a >= 7'h4F) ? 7'h00 : a + 7'd1;
         if (a == 7'h00 || a > 7'h4F) return 7'h4F;
         return a - 7'd1;
      end
      if (up) begin
         if (a >= 7'h27 && a < 7'h40) return 7'h40;
         if (a >= 7'h67) return 7'h00;
         return a + 7'd1;
      end
      if (a == 7'h00 || a > 7'h67) return 7'h67;
      if (a > 7'h27 && a <= 7'h40) return 7'h27;
      return a - 7'd1;
   endfunction

   function automatic string tag(input logic ld, input logic up, input logic dn,
                                 input logic tl, input logic tc);
      if (ld) return "R2";
      if (up == dn) return "R8";
      if (tc) return "R7";
      if (tl) return up ? "R5" : "R6";
      return up ? "R3" : "R4";
   endfunction

   task automatic check(input string req, input logic [6:0] exp);
      n_cmp++;
      if (addr !== exp) begin
         n_bad++;
         $display("FAIL %s: addr=%02h expected=%02h", req, addr, exp);
      end
   endtask

   task automatic step(input logic ld, input logic [6:0] lv, input logic up, input logic dn,
                       input logic tl, input logic tc, input bit do_chk);
      logic [6:0] exp;
      load_en = ld; load_val = lv; inc = up; dec = dn; two_line = tl; tgt_char = tc;
      exp = model(shadow, ld, lv, up, dn, tl, tc);
      @(posedge clk);
      @(negedge clk);
      shadow = exp;
      if (do_chk) check(tag(ld, up, dn, tl, tc), exp);
      load_en = 0; inc = 0; dec = 0;
   endtask

   task automatic ld_then(input logic [6:0] v, input logic up, input logic tl, input logic tc);
      step(1, v, 0, 0, tl, tc, 1);
      step(0, 7'h00, up, !up, tl, tc, 1);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      check("R1", 7'h00);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1", 7'h00);

      // R3 / R4 one-line boundaries
      ld_then(7'h4F, 1, 0, 0);
      ld_then(7'h4E, 1, 0, 0);
      ld_then(7'h60, 1, 0, 0);
      ld_then(7'h00, 0, 0, 0);
      ld_then(7'h55, 0, 0, 0);
      ld_then(7'h10, 0, 0, 0);
      // R5 / R6 two-line seams and hole
      ld_then(7'h27, 1, 1, 0);
      ld_then(7'h30, 1, 1, 0);
      ld_then(7'h67, 1, 1, 0);
      ld_then(7'h7F, 1, 1, 0);
      ld_then(7'h40, 0, 1, 0);
      ld_then(7'h00, 0, 1, 0);
      ld_then(7'h35, 0, 1, 0);
      ld_then(7'h70, 0, 1, 0);
      // R7 glyph wrap, line mode ignored
      ld_then(7'h3F, 1, 1, 1);
      ld_then(7'h00, 0, 0, 1);
      ld_then(7'h7F, 0, 1, 1);
      // R2 load overrides strobes
      step(1, 7'h55, 1, 1, 0, 0, 1);
      step(1, 7'h55, 1, 0, 0, 1, 1);
      // R8 hold with both strobes / none
      step(0, 7'h00, 1, 1, 1, 0, 1);
      step(0, 7'h00, 0, 0, 0, 0, 1);

      for (int i = 0; i < 3000; i++) begin
         logic [6:0] v;
         int pick;
         pick = $urandom_range(0, 7);
         case ($urandom_range(0, 5))
            0: v = 7'h27 + 7'($urandom_range(0, 2)) - 7'd1;
            1: v = 7'h40 + 7'($urandom_range(0, 2)) - 7'd1;
            2: v = 7'h4E + 7'($urandom_range(0, 2));
            3: v = 7'h66 + 7'($urandom_range(0, 2));
            4: v = 7'($urandom_range(0, 1));
            default: v = 7'($urandom_range(0, 127));
         endcase
         step(pick == 0, v, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, 1);
      end

      // R9: load then step in two-line layout, whole address range
      for (int k = 0; k < 128; k++) begin
         step(1, 7'(k), 0, 0, 1, 0, 1);
         step(0, 7'h00, k[0], !k[0], 1, 0, 0);
         n_cmp++;
         if ((addr > 7'h27 && addr < 7'h40) || addr > 7'h67 || addr !== shadow) begin
            n_bad++;
            $display("FAIL R9: addr=%02h expected=%02h", addr, shadow);
         end
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule